// File: doc/BRIEF.md
# PoE Port Power Sequencer

This block runs the power state of every port of a multi-port power-sourcing switch. Each port steps through signature detection, class check, a wait for a ramp slot, a controlled ramp with an inrush current limit, and steady-state operation. Any problem drops the port into a fault state with a distinct cause code and a one-cycle event strobe that a logger can timestamp. Analog sensing is outside the block: every condition arrives as a debounced flag per port.

After a fault the port waits out a backoff that doubles with each consecutive fault and saturates. A long enough spell of healthy operation forgets the fault history. Heat faults also wait for a cooldown input. Repeated signature, class or short faults lock the port until an operator clear. A shared arbiter hands out ramp slots round-robin, one port at a time, with a minimum spacing between slots. All times are counted in millisecond ticks from a clock prescaler.

Top module: `poe_seq_top`

## Requirements
- R1: After reset every port is in state DETECT (code 0), its gate is off, its cause code is NONE (0) and no event strobe is high.
- R2: A port whose signature and class are good passes DETECT(0), CLASSIFY(1), WAIT(2), RAMP(3) and reaches MAINT(4); the gate is on in RAMP and MAINT, and the current-limit select is 0 (inrush limit) in RAMP and 1 (run limit) in MAINT.
- R3: Over-current during the first INRUSH_MS ms of RAMP is ignored; if it is still present when the window ends the port faults with cause OC (2).
- R4: In MAINT, over-current, over-temperature and under-voltage fault the port at once with causes OC (2), OT (3) and UV (4); when several are present OC wins over OT, and OT over UV.
- R5: In MAINT, loss of the maintain signature faults the port with cause DISC (1) only when it lasts more than MPS_MS ms; a shorter loss has no effect.
- R6: Every entry into FAULT(5) or LOCKOUT(6) raises the event strobe for exactly one cycle, with the new cause code already present, and turns the gate off.
- R7: The k-th consecutive fault (k from 0) holds the port in FAULT for BASE_MS << min(k, MAX_SHIFT) ms before it returns to DETECT; it never re-enables at once.
- R8: After HOLD_MS ms of continuous MAINT the fault history is cleared, so the next backoff is BASE_MS again.
- R9: A port in FAULT with cause OT stays there until the cooldown input is high, even after its backoff has ended.
- R10: The LOCK_N-th consecutive signature, class or OC fault enters LOCKOUT(6) with the gate off; only the operator clear leaves it, returning to DETECT with the fault history cleared.
- R11: At most one port is in RAMP at any time; ramp slots go round-robin starting at port 0 and successive slots are at least STAGGER_MS ms apart.
- R12: A bad signature in DETECT faults the port with cause DET (5); a bad class in CLASSIFY faults it with cause CLS (6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| detOk | input | NPORTS | Valid signature seen, per port |
| detBad | input | NPORTS | Invalid signature seen, per port |
| clsOk | input | NPORTS | Class result acceptable, per port |
| clsBad | input | NPORTS | Class result rejected, per port |
| ocFlag | input | NPORTS | Over-current comparator, per port |
| uvFlag | input | NPORTS | Under-voltage comparator, per port |
| otFlag | input | NPORTS | Over-temperature comparator, per port |
| mpsPresent | input | NPORTS | Maintain signature present, per port |
| coolDone | input | NPORTS | Cooldown complete after a heat fault, per port |
| opClear | input | NPORTS | Operator clear of a lockout, per port |
| gateEn | output | NPORTS | Power switch gate enable |
| curLimRun | output | NPORTS | Current-limit select: 0 inrush, 1 run |
| portState | output | 3*NPORTS | State code per port, port p at bits 3p+2..3p |
| reason | output | 3*NPORTS | Last fault cause per port, same packing |
| evtStb | output | NPORTS | One-cycle event strobe on fault or lockout entry |

## Verification
The hardest situation to reach is the saturated backoff and the lockout, because each needs a chain of consecutive faults of particular kinds with no healthy spell long enough to clear the history between them. The stimulus drives one port through a planned run of disconnect, under-voltage, held inrush over-current, heat and further faults, measuring each backoff against the doubling rule, then a run of bad signatures into lockout. Randomly placed over-current pulses inside the inrush window, and a simultaneous start of all ports for the ramp slots, cover blanking and staggering.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

  typedef enum logic [2:0] {
    ST_DETECT   = 3'd0,
    ST_CLASSIFY = 3'd1,
    ST_WAIT     = 3'd2,
    ST_RAMP     = 3'd3,
    ST_MAINT    = 3'd4,
    ST_FAULT    = 3'd5,
    ST_LOCK     = 3'd6
  } portState_e;

  typedef enum logic [2:0] {
    RS_NONE = 3'd0,
    RS_DISC = 3'd1,
    RS_OC   = 3'd2,
    RS_OT   = 3'd3,
    RS_UV   = 3'd4,
    RS_DET  = 3'd5,
    RS_CLS  = 3'd6
  } reason_e;

  // strobes from the control FSM to the timer datapath
  typedef struct packed {
    logic stateEntry;  // state changes at the coming edge
    logic faultEntry;  // any fault or lockout entry
    logic lockable;    // that fault counts towards lockout
    logic clearHist;   // forget backoff and lockout history
    logic inMaint;     // port is in steady state
  } ctrlStb_t;

  // conditions from the timer datapath to the control FSM
  typedef struct packed {
    logic inrushDone;
    logic backoffDone;
    logic mpsLost;
    logic holdDone;
    logic lockNext;
  } dpFlags_t;

endpackage

// File: rtl/poe_port_timers.sv
module poe_port_timers
  import poe_seq_pkg::*;
#(
  parameter int INRUSH_MS = 64,
  parameter int MPS_MS    = 300,
  parameter int BASE_MS   = 1000,
  parameter int MAX_SHIFT = 5,
  parameter int HOLD_MS   = 10000,
  parameter int LOCK_N    = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     msTick,
  input  logic     mpsPresent,
  input  ctrlStb_t stb,
  output dpFlags_t flags
);

  localparam int MAXB = BASE_MS << MAX_SHIFT;
  localparam int T1   = (MAXB > HOLD_MS) ? MAXB : HOLD_MS;
  localparam int T2   = (T1 > INRUSH_MS) ? T1 : INRUSH_MS;
  localparam int T3   = (T2 > MPS_MS) ? T2 : MPS_MS;
  localparam int TSAT = T3 + 1;
  localparam int TW   = $clog2(TSAT + 1);
  localparam int SW   = $clog2(MAX_SHIFT + 1);
  localparam int LW   = $clog2(LOCK_N + 1);

  logic [TW-1:0] stateTmr;
  logic [TW-1:0] mpsTmr;
  logic [SW-1:0] expCnt;
  logic [SW-1:0] shiftLat;
  logic [LW-1:0] lockCnt;
  logic [TW-1:0] backoffLim;

  assign backoffLim = TW'(BASE_MS) << shiftLat;

  // time spent in the current state
  always_ff @(posedge clk) begin
    if (!rstN || stb.stateEntry) begin
      stateTmr <= '0;
    end else if (msTick && stateTmr != TW'(TSAT)) begin
      stateTmr <= stateTmr + 1'b1;
    end
  end

  // continuous loss of maintain signature while powered
  always_ff @(posedge clk) begin
    if (!rstN || !stb.inMaint || mpsPresent) begin
      mpsTmr <= '0;
    end else if (msTick && mpsTmr != TW'(TSAT)) begin
      mpsTmr <= mpsTmr + 1'b1;
    end
  end

  // consecutive-fault history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      expCnt   <= '0;
      shiftLat <= '0;
      lockCnt  <= '0;
    end else if (stb.clearHist) begin
      expCnt  <= '0;
      lockCnt <= '0;
    end else if (stb.faultEntry) begin
      shiftLat <= expCnt;
      if (expCnt != SW'(MAX_SHIFT)) expCnt <= expCnt + 1'b1;
      if (stb.lockable && lockCnt != LW'(LOCK_N)) lockCnt <= lockCnt + 1'b1;
    end
  end

  assign flags.inrushDone  = stateTmr >= TW'(INRUSH_MS);
  assign flags.backoffDone = stateTmr >= backoffLim;
  assign flags.mpsLost     = mpsTmr > TW'(MPS_MS);
  assign flags.holdDone    = stateTmr >= TW'(HOLD_MS);
  assign flags.lockNext    = lockCnt == LW'(LOCK_N - 1);

  // backoff shift never exceeds the cap
  p_shift_cap_r7 : assert property (@(posedge clk) disable iff (!rstN)
    shiftLat <= SW'(MAX_SHIFT));

endmodule

// File: rtl/poe_port_ctrl.sv
module poe_port_ctrl
  import poe_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       detOk,
  input  logic       detBad,
  input  logic       clsOk,
  input  logic       clsBad,
  input  logic       ocFlag,
  input  logic       uvFlag,
  input  logic       otFlag,
  input  logic       coolDone,
  input  logic       opClear,
  input  logic       grant,
  input  dpFlags_t   flags,
  output ctrlStb_t   stb,
  output portState_e stateOut,
  output reason_e    reasonOut,
  output logic       evtStb,
  output logic       gateEn,
  output logic       curLimRun,
  output logic       rampReq,
  output logic       inRamp
);

  portState_e state, nxtState;
  reason_e    reason, faultCode;
  logic       fault, lockable;

  always_comb begin
    nxtState  = state;
    faultCode = RS_NONE;
    fault     = 1'b0;
    lockable  = 1'b0;
    case (state)
      ST_DETECT: begin
        if (detBad) begin
          fault = 1'b1; faultCode = RS_DET; lockable = 1'b1;
        end else if (detOk) begin
          nxtState = ST_CLASSIFY;
        end
      end
      ST_CLASSIFY: begin
        if (clsBad) begin
          fault = 1'b1; faultCode = RS_CLS; lockable = 1'b1;
        end else if (clsOk) begin
          nxtState = ST_WAIT;
        end
      end
      ST_WAIT: if (grant) nxtState = ST_RAMP;
      ST_RAMP: begin
        if (otFlag) begin
          fault = 1'b1; faultCode = RS_OT;
        end else if (uvFlag) begin
          fault = 1'b1; faultCode = RS_UV;
        end else if (flags.inrushDone) begin
          if (ocFlag) begin
            fault = 1'b1; faultCode = RS_OC; lockable = 1'b1;
          end else begin
            nxtState = ST_MAINT;
          end
        end
      end
      ST_MAINT: begin
        if (ocFlag) begin
          fault = 1'b1; faultCode = RS_OC; lockable = 1'b1;
        end else if (otFlag) begin
          fault = 1'b1; faultCode = RS_OT;
        end else if (uvFlag) begin
          fault = 1'b1; faultCode = RS_UV;
        end else if (flags.mpsLost) begin
          fault = 1'b1; faultCode = RS_DISC;
        end
      end
      ST_FAULT: begin
        if (flags.backoffDone && (reason != RS_OT || coolDone)) nxtState = ST_DETECT;
      end
      ST_LOCK: if (opClear) nxtState = ST_DETECT;
      default: nxtState = ST_DETECT;
    endcase
    if (fault) nxtState = (lockable && flags.lockNext) ? ST_LOCK : ST_FAULT;
  end

  always_comb begin
    stb.stateEntry = nxtState != state;
    stb.faultEntry = fault;
    stb.lockable   = fault && lockable;
    stb.inMaint    = state == ST_MAINT;
    stb.clearHist  = (state == ST_LOCK && opClear) ||
                     (state == ST_MAINT && flags.holdDone && !fault);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_DETECT;
      reason <= RS_NONE;
      evtStb <= 1'b0;
    end else begin
      state  <= nxtState;
      evtStb <= fault;
      if (fault) reason <= faultCode;
    end
  end

  assign stateOut  = state;
  assign reasonOut = reason;
  assign gateEn    = state == ST_RAMP || state == ST_MAINT;
  assign curLimRun = state == ST_MAINT;
  assign rampReq   = state == ST_WAIT;
  assign inRamp    = state == ST_RAMP;

  // event strobe lasts one cycle and comes with a cause
  p_stb_pulse_r6 : assert property (@(posedge clk) disable iff (!rstN)
    evtStb |=> !evtStb);
  p_stb_cause_r6 : assert property (@(posedge clk) disable iff (!rstN)
    evtStb |-> ((state == ST_FAULT || state == ST_LOCK) && reason != RS_NONE));
  // over-current is blanked inside the inrush window
  p_oc_blank_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RAMP && !flags.inrushDone && !otFlag && !uvFlag) |=> state == ST_RAMP);
  // heat fault waits for cooldown
  p_ot_hold_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAULT && reason == RS_OT && !coolDone) |=> state == ST_FAULT);
  // lockout is left only by operator clear
  p_lock_stay_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && !opClear) |=> state == ST_LOCK);
  // a granted slot starts the ramp
  p_grant_ramp_r11 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && grant) |=> state == ST_RAMP);

endmodule

// File: rtl/poe_stagger_arb.sv
module poe_stagger_arb #(
  parameter int NPORTS     = 4,
  parameter int STAGGER_MS = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic [NPORTS-1:0] req,
  input  logic [NPORTS-1:0] ramping,
  output logic [NPORTS-1:0] grant
);

  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int GW = $clog2(STAGGER_MS + 1);

  logic [PW-1:0] ptr, sel;
  logic [GW-1:0] gapCnt;
  logic          found;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NPORTS; i++) begin
      int idx;
      idx = (int'(ptr) + i) % NPORTS;
      if (!found && req[idx]) begin
        found = 1'b1;
        sel   = PW'(idx);
      end
    end
    grant = '0;
    if (found && gapCnt == '0 && ramping == '0) grant[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr    <= '0;
      gapCnt <= '0;
    end else if (|grant) begin
      gapCnt <= GW'(STAGGER_MS);
      ptr    <= (int'(sel) == NPORTS - 1) ? '0 : sel + 1'b1;
    end else if (msTick && gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  p_one_ramp_r11 : assert property (@(posedge clk) disable iff (!rstN)
    $countones(ramping) <= 1);
  p_grant_onehot_r11 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  p_grant_gap_r11 : assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |=> grant == '0);

endmodule

// File: rtl/poe_seq_top.sv
module poe_seq_top
  import poe_seq_pkg::*;
#(
  parameter int NPORTS     = 4,
  parameter int CLK_PER_MS = 100000,
  parameter int INRUSH_MS  = 64,
  parameter int MPS_MS     = 300,
  parameter int BASE_MS    = 1000,
  parameter int MAX_SHIFT  = 5,
  parameter int HOLD_MS    = 10000,
  parameter int STAGGER_MS = 100,
  parameter int LOCK_N     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NPORTS-1:0]   detOk,
  input  logic [NPORTS-1:0]   detBad,
  input  logic [NPORTS-1:0]   clsOk,
  input  logic [NPORTS-1:0]   clsBad,
  input  logic [NPORTS-1:0]   ocFlag,
  input  logic [NPORTS-1:0]   uvFlag,
  input  logic [NPORTS-1:0]   otFlag,
  input  logic [NPORTS-1:0]   mpsPresent,
  input  logic [NPORTS-1:0]   coolDone,
  input  logic [NPORTS-1:0]   opClear,
  output logic [NPORTS-1:0]   gateEn,
  output logic [NPORTS-1:0]   curLimRun,
  output logic [3*NPORTS-1:0] portState,
  output logic [3*NPORTS-1:0] reason,
  output logic [NPORTS-1:0]   evtStb
);

  localparam int PCW = $clog2(CLK_PER_MS + 1);

  logic [PCW-1:0]    preCnt;
  logic              msTick;
  logic [NPORTS-1:0] rampReq, inRamp, grant;

  assign msTick = preCnt == PCW'(CLK_PER_MS - 1);

  always_ff @(posedge clk) begin
    if (!rstN || msTick) preCnt <= '0;
    else                 preCnt <= preCnt + 1'b1;
  end

  poe_stagger_arb #(.NPORTS(NPORTS), .STAGGER_MS(STAGGER_MS)) i_arb (
    .clk(clk), .rstN(rstN), .msTick(msTick),
    .req(rampReq), .ramping(inRamp), .grant(grant)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    ctrlStb_t   stb;
    dpFlags_t   flags;
    portState_e st;
    reason_e    rs;

    poe_port_ctrl i_ctrl (
      .clk(clk), .rstN(rstN),
      .detOk(detOk[p]), .detBad(detBad[p]), .clsOk(clsOk[p]), .clsBad(clsBad[p]),
      .ocFlag(ocFlag[p]), .uvFlag(uvFlag[p]), .otFlag(otFlag[p]),
      .coolDone(coolDone[p]), .opClear(opClear[p]), .grant(grant[p]),
      .flags(flags), .stb(stb), .stateOut(st), .reasonOut(rs),
      .evtStb(evtStb[p]), .gateEn(gateEn[p]), .curLimRun(curLimRun[p]),
      .rampReq(rampReq[p]), .inRamp(inRamp[p])
    );

    poe_port_timers #(
      .INRUSH_MS(INRUSH_MS), .MPS_MS(MPS_MS), .BASE_MS(BASE_MS),
      .MAX_SHIFT(MAX_SHIFT), .HOLD_MS(HOLD_MS), .LOCK_N(LOCK_N)
    ) i_tmr (
      .clk(clk), .rstN(rstN), .msTick(msTick),
      .mpsPresent(mpsPresent[p]), .stb(stb), .flags(flags)
    );

    assign portState[3*p +: 3] = st;
    assign reason[3*p +: 3]    = rs;
  end

endmodule

// File: tb/test_poe_seq_top.sv
module test_poe_seq_top;

  localparam int N      = 3;
  localparam int INRUSH = 8;
  localparam int MPSMS  = 6;
  localparam int BASE   = 20;
  localparam int MAXS   = 2;
  localparam int HOLD   = 50;
  localparam int STAG   = 12;
  localparam int LOCKN  = 3;

  localparam int S_DET = 0, S_CLS = 1, S_RAMP = 3, S_MAINT = 4, S_FAULT = 5, S_LOCK = 6;
  localparam int C_DISC = 1, C_OC = 2, C_OT = 3, C_UV = 4, C_DET = 5, C_CLS = 6;

  logic clk = 0;
  logic rstN = 0;
  logic [N-1:0] detOk = 0, detBad = 0, clsOk = 0, clsBad = 0, ocFlag = 0, uvFlag = 0;
  logic [N-1:0] otFlag = 0, mpsPresent = 0, coolDone = 0, opClear = 0;
  logic [N-1:0] gateEn, curLimRun, evtStb;
  logic [3*N-1:0] portState, reason;

  int nChecks = 0, nErrors = 0, cyc = 0;
  int rampViol = 0, nRec = 0;
  int recPort[8], recTime[8];
  int prevSt[N];
  bit recOn = 0;

  always #5 clk = ~clk;

  poe_seq_top #(
    .NPORTS(N), .CLK_PER_MS(1), .INRUSH_MS(INRUSH), .MPS_MS(MPSMS), .BASE_MS(BASE),
    .MAX_SHIFT(MAXS), .HOLD_MS(HOLD), .STAGGER_MS(STAG), .LOCK_N(LOCKN)
  ) i_poe_seq_top (
    .clk(clk), .rstN(rstN), .detOk(detOk), .detBad(detBad), .clsOk(clsOk), .clsBad(clsBad),
    .ocFlag(ocFlag), .uvFlag(uvFlag), .otFlag(otFlag), .mpsPresent(mpsPresent),
    .coolDone(coolDone), .opClear(opClear), .gateEn(gateEn), .curLimRun(curLimRun),
    .portState(portState), .reason(reason), .evtStb(evtStb)
  );

  function automatic int st(int p);
    return int'(portState[3*p +: 3]);
  endfunction

  function automatic int rs(int p);
    return int'(reason[3*p +: 3]);
  endfunction

  // expected cycles spent in FAULT for the k-th consecutive fault (1 ms per cycle)
  function automatic int expBackoff(int k);
    return (BASE << ((k > MAXS) ? MAXS : k)) + 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitState(int p, int s, int tmo);
    for (int i = 0; i < tmo && st(p) != s; i++) @(negedge clk);
  endtask

  task automatic countFault(int p, output int n);
    n = 0;
    while (st(p) == S_FAULT && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // ramp-slot monitor
  always @(negedge clk) begin
    int cnt;
    cyc++;
    cnt = 0;
    for (int p = 0; p < N; p++) begin
      if (st(p) == S_RAMP) cnt++;
      if (recOn && prevSt[p] != S_RAMP && st(p) == S_RAMP && nRec < 8) begin
        recPort[nRec] = p;
        recTime[nRec] = cyc;
        nRec++;
      end
      prevSt[p] = st(p);
    end
    if (cnt > 1) rampViol++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    for (int p = 0; p < N; p++) begin
      chk(st(p) == S_DET && gateEn[p] == 0 && rs(p) == 0 && evtStb[p] == 0,
          "R1 reset state", st(p), S_DET);
    end

    // R11 / R2: all ports start together
    recOn = 1;
    detOk = '1; clsOk = '1; mpsPresent = '1;
    waitState(0, S_RAMP, 100);
    chk(gateEn[0] == 1 && curLimRun[0] == 0, "R2 ramp gate/inrush limit",
        {gateEn[0], curLimRun[0]}, 2);
    for (int p = 0; p < N; p++) waitState(p, S_MAINT, 200);
    for (int p = 0; p < N; p++)
      chk(st(p) == S_MAINT && gateEn[p] && curLimRun[p], "R2 reach maintain", st(p), S_MAINT);
    recOn = 0;
    chk(nRec == 3, "R11 ramp count", nRec, 3);
    chk(recPort[0] == 0 && recPort[1] == 1 && recPort[2] == 2, "R11 round-robin order",
        recPort[0]*100 + recPort[1]*10 + recPort[2], 12);
    chk(recTime[1] - recTime[0] >= STAG && recTime[2] - recTime[1] >= STAG,
        "R11 slot spacing", recTime[1] - recTime[0], STAG);

    // park ports 1 and 2
    detOk[2:1] = 0; mpsPresent[2:1] = 0;

    // R5 short loss ignored
    mpsPresent[0] = 0;
    repeat (MPSMS - 2) @(negedge clk);
    mpsPresent[0] = 1;
    repeat (20) @(negedge clk);
    chk(st(0) == S_MAINT, "R5 short signature loss ignored", st(0), S_MAINT);

    // R5 / R6 long loss -> DISC, first backoff
    mpsPresent[0] = 0;
    waitState(0, S_FAULT, 100);
    mpsPresent[0] = 1;
    chk(rs(0) == C_DISC, "R5 disconnect cause", rs(0), C_DISC);
    chk(evtStb[0] == 1 && gateEn[0] == 0, "R6 strobe and gate off", {evtStb[0], gateEn[0]}, 2);
    countFault(0, n);
    chk(n == expBackoff(0), "R7 backoff k=0", n, expBackoff(0));

    // R3 random OC pulses inside the inrush window
    waitState(0, S_RAMP, 200);
    for (int i = 0; i < INRUSH - 2; i++) begin
      ocFlag[0] = 1'($urandom_range(1, 0));
      @(negedge clk);
    end
    ocFlag[0] = 0;
    waitState(0, S_MAINT, 50);
    chk(st(0) == S_MAINT, "R3 inrush over-current blanked", st(0), S_MAINT);

    // R4 under-voltage, second backoff
    uvFlag[0] = 1;
    waitState(0, S_FAULT, 20);
    uvFlag[0] = 0;
    chk(rs(0) == C_UV, "R4 under-voltage cause", rs(0), C_UV);
    countFault(0, n);
    chk(n == expBackoff(1), "R7 backoff k=1", n, expBackoff(1));

    // R3 over-current held past the window
    waitState(0, S_RAMP, 200);
    ocFlag[0] = 1;
    repeat (INRUSH - 1) @(negedge clk);
    chk(st(0) == S_RAMP && gateEn[0], "R3 still ramping in window", st(0), S_RAMP);
    waitState(0, S_FAULT, 20);
    ocFlag[0] = 0;
    chk(rs(0) == C_OC, "R3 over-current at window end", rs(0), C_OC);
    countFault(0, n);
    chk(n == expBackoff(2), "R7 backoff k=2", n, expBackoff(2));

    // R4 priority OT over UV, R9 cooldown wait
    waitState(0, S_MAINT, 200);
    otFlag[0] = 1; uvFlag[0] = 1;
    waitState(0, S_FAULT, 20);
    otFlag[0] = 0; uvFlag[0] = 0;
    chk(rs(0) == C_OT, "R4 heat wins over under-voltage", rs(0), C_OT);
    repeat (120) @(negedge clk);
    chk(st(0) == S_FAULT, "R9 held until cooldown", st(0), S_FAULT);
    coolDone[0] = 1;
    repeat (2) @(negedge clk);
    coolDone[0] = 0;
    chk(st(0) != S_FAULT, "R9 retry after cooldown", st(0), S_DET);

    // R7 saturation
    waitState(0, S_MAINT, 200);
    mpsPresent[0] = 0;
    waitState(0, S_FAULT, 50);
    mpsPresent[0] = 1;
    countFault(0, n);
    chk(n == expBackoff(4), "R7 backoff saturates", n, expBackoff(4));

    // R8 history cleared by long maintain
    waitState(0, S_MAINT, 200);
    repeat (HOLD + 5) @(negedge clk);
    mpsPresent[0] = 0;
    waitState(0, S_FAULT, 50);
    mpsPresent[0] = 1;
    detOk[0] = 0; detBad[0] = 1;
    countFault(0, n);
    chk(n == expBackoff(0), "R8 backoff restarts", n, expBackoff(0));

    // R12 / R10 signature faults into lockout
    waitState(0, S_FAULT, 20);
    chk(rs(0) == C_DET, "R12 bad signature cause", rs(0), C_DET);
    waitState(0, S_LOCK, 1000);
    chk(st(0) == S_LOCK && rs(0) == C_DET, "R10 lockout entered", st(0), S_LOCK);
    repeat (100) @(negedge clk);
    chk(st(0) == S_LOCK && gateEn[0] == 0, "R10 lockout holds", st(0), S_LOCK);
    detBad[0] = 0; detOk[0] = 1; clsOk[0] = 0; clsBad[0] = 1;
    opClear[0] = 1;
    @(negedge clk);
    opClear[0] = 0;
    chk(st(0) == S_DET, "R10 clear returns to detect", st(0), S_DET);
    waitState(0, S_FAULT, 20);
    chk(rs(0) == C_CLS, "R12 bad class cause", rs(0), C_CLS);
    countFault(0, n);
    chk(n == expBackoff(0), "R10 clear resets history", n, expBackoff(0));

    chk(rampViol == 0, "R11 single ramp at a time", rampViol, 0);

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule